// File: doc/BRIEF.md
# Serial-Controlled Four-Pin I/O Expander Core

This block gives a host four general-purpose pins that it reaches over a two-wire serial bus, with the block acting as a slave at one fixed address. Each pin can be set up as an input or as an output. Output pins drive the value the host has written. Input pins are sampled, passed through a per-pin inversion mask and returned on a read. An active-low interrupt tells the host that an input pin has moved away from the value it last read.

The bus lines and the pins are synchronized into the core clock domain. A byte-level slave state machine then decodes START, STOP, address, command and data bytes. The first byte written after the address is a pointer that selects one of four registers: input, output, inversion and direction. The bytes that follow in the same transfer, whether written or read, go to that register.

An active-low reset returns every register to its default and puts the bus machine back to idle. It has the same effect as power-up.

Top module: `gpio_expander_core`

## Requirements
- R1: After reset, all pins are inputs (`pin_oe` = 0), `int_n` is 1 and `pin_o` is 4'hF. The registers read back output = 8'h0F, inversion = 8'h00 and direction = 8'h0F. Register bits above the pin count always read as zero.
- R2: The slave answers only address 7'h49, with the read/write flag in bit 0 of the address byte (1 = read). For any other address, SDA stays released in the acknowledge slot and no register changes.
- R3: In a write transfer, bits [1:0] of the first byte after the address select the register: 0 = input, 1 = output, 2 = inversion, 3 = direction. Every later byte in the transfer is written to that same register, and later reads return that register.
- R4: A direction bit of 1 makes its pin an input and 0 makes it an output. `pin_oe[i]` equals the inverse of direction bit i.
- R5: `pin_o` always equals the output register. `pin_o` and `pin_oe` change only when a register is written.
- R6: A read of the input register returns the synchronized pin levels XOR the inversion register, in bits [3:0].
- R7: `int_n` goes low when an input-direction pin's synchronized level differs from its snapshot. Differences on output-direction pins are ignored.
- R8: A read of the input register copies the current pin levels into the snapshot, which releases `int_n`. `int_n` is also released when the pins return to the snapshot values. The snapshot resets to zero.
- R9: The slave pulls SDA low in the acknowledge slot after a matching address and after each written byte. On reads it shifts data out MSB first. It sends another byte after a master ACK and stops after a master NACK.
- R10: Data written to the input register is discarded.
- R11: A reset in the middle of a transfer restores the register defaults and returns the slave to idle, ready for the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| pin_i | input | 4 | Pad input levels |
| pin_o | output | 4 | Pad output values |
| pin_oe | output | 4 | Pad output enables, 1 = driven |
| int_n | output | 1 | Active-low change interrupt (open-drain style) |

## Verification
The assertions check, on every cycle, that a reset leaves every pad undriven with the interrupt released. They also check that pad drive and output values stay still unless a register write occurs, and that the interrupt only falls after a pin or direction change. Two further checks are that an input-register read releases the interrupt unless the pins move at that moment, and that the slave only starts pulling SDA while the synchronized clock is low. The bench's scenarios are what show the register selection by command byte, the address filtering, the inversion applied to read data and the discarding of writes to the input register. They also cover that output-direction pins are ignored by the interrupt, multi-byte transfers in both directions, and recovery from a reset in the middle of a transfer.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
   // register selector carried in bits [1:0] of the command byte
   typedef enum logic [1:0] {
      SEL_INPUT    = 2'd0,
      SEL_OUTPUT   = 2'd1,
      SEL_POLARITY = 2'd2,
      SEL_CONFIG   = 2'd3
   } gpx_sel_e;

   typedef enum logic [2:0] {
      BS_IDLE,
      BS_ADDR,
      BS_AACK,
      BS_WDATA,
      BS_WACK,
      BS_RDATA,
      BS_RACK
   } gpx_bus_state_e;

   localparam int GPX_BYTE_W = 8;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
      end else begin
         chain_q[0] <= d;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpx_slave.sv
module gpx_slave
   import gpx_pkg::*;
#(
   parameter int         NPINS      = 4,
   parameter logic [6:0] SLAVE_ADDR = 7'h49
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_s,
   input  logic             sda_s,
   output logic             sda_oe,
   output logic             wr_en,
   output gpx_sel_e         ptr,
   output logic [NPINS-1:0] wr_data,
   input  logic [NPINS-1:0] rd_data,
   output logic             rd_cap
);
   localparam logic [3:0] LAST_BIT = 4'(GPX_BYTE_W);

   gpx_bus_state_e        st_q;
   logic [3:0]            bit_q;
   logic [GPX_BYTE_W-1:0] sh_q;
   logic                  rw_q, cmd_q, mack_q, scl_q, sda_q;
   logic [GPX_BYTE_W-1:0] rd_byte;

   wire scl_rise = scl_s & ~scl_q;
   wire scl_fall = ~scl_s & scl_q;
   wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
   wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;

   always_comb begin
      rd_byte = '0;
      rd_byte[NPINS-1:0] = rd_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= BS_IDLE;
         bit_q   <= '0;
         sh_q    <= '0;
         rw_q    <= 1'b0;
         cmd_q   <= 1'b0;
         mack_q  <= 1'b0;
         scl_q   <= 1'b1;
         sda_q   <= 1'b1;
         sda_oe  <= 1'b0;
         wr_en   <= 1'b0;
         rd_cap  <= 1'b0;
         ptr     <= SEL_INPUT;
         wr_data <= '0;
      end else begin
         scl_q  <= scl_s;
         sda_q  <= sda_s;
         wr_en  <= 1'b0;
         rd_cap <= 1'b0;
         if (start_c) begin
            st_q   <= BS_ADDR;
            bit_q  <= '0;
            sda_oe <= 1'b0;
         end else if (stop_c) begin
            st_q   <= BS_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (st_q)
               BS_ADDR, BS_WDATA: begin
                  if (scl_rise) begin
                     sh_q  <= {sh_q[GPX_BYTE_W-2:0], sda_s};
                     bit_q <= bit_q + 4'd1;
                  end else if (scl_fall && bit_q == LAST_BIT) begin
                     if (st_q == BS_ADDR) begin
                        if (sh_q[7:1] == SLAVE_ADDR) begin
                           st_q   <= BS_AACK;
                           sda_oe <= 1'b1;
                           rw_q   <= sh_q[0];
                           cmd_q  <= ~sh_q[0];
                        end else begin
                           st_q <= BS_IDLE;
                        end
                     end else begin
                        st_q   <= BS_WACK;
                        sda_oe <= 1'b1;
                        if (cmd_q) begin
                           ptr   <= gpx_sel_e'(sh_q[1:0]);
                           cmd_q <= 1'b0;
                        end else begin
                           wr_en   <= 1'b1;
                           wr_data <= sh_q[NPINS-1:0];
                        end
                     end
                  end
               end
               BS_AACK: begin
                  if (scl_fall) begin
                     bit_q <= '0;
                     if (rw_q) begin
                        sh_q   <= rd_byte;
                        sda_oe <= ~rd_byte[GPX_BYTE_W-1];
                        rd_cap <= (ptr == SEL_INPUT);
                        st_q   <= BS_RDATA;
                     end else begin
                        sda_oe <= 1'b0;
                        st_q   <= BS_WDATA;
                     end
                  end
               end
               BS_WACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     bit_q  <= '0;
                     st_q   <= BS_WDATA;
                  end
               end
               BS_RDATA: begin
                  if (scl_rise) begin
                     bit_q <= bit_q + 4'd1;
                  end else if (scl_fall) begin
                     if (bit_q == LAST_BIT) begin
                        sda_oe <= 1'b0;
                        st_q   <= BS_RACK;
                     end else begin
                        sh_q   <= {sh_q[GPX_BYTE_W-2:0], 1'b0};
                        sda_oe <= ~sh_q[GPX_BYTE_W-2];
                     end
                  end
               end
               BS_RACK: begin
                  if (scl_rise) begin
                     mack_q <= ~sda_s;
                  end else if (scl_fall) begin
                     if (mack_q) begin
                        bit_q  <= '0;
                        sh_q   <= rd_byte;
                        sda_oe <= ~rd_byte[GPX_BYTE_W-1];
                        rd_cap <= (ptr == SEL_INPUT);
                        st_q   <= BS_RDATA;
                     end else begin
                        st_q <= BS_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
   import gpx_pkg::*;
#(
   parameter int NPINS           = 4,
   parameter bit IRQ_INPUTS_ONLY = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pin_s,
   input  logic             wr_en,
   input  gpx_sel_e         sel,
   input  logic [NPINS-1:0] wr_data,
   input  logic             rd_cap,
   output logic [NPINS-1:0] rd_data,
   output logic [NPINS-1:0] pin_o,
   output logic [NPINS-1:0] pin_oe,
   output logic             int_n
);
   logic [NPINS-1:0] out_q, pol_q, cfg_q, snap_q, watch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q  <= '1;
         pol_q  <= '0;
         cfg_q  <= '1;
         snap_q <= '0;
      end else begin
         if (wr_en) begin
            case (sel)
               SEL_OUTPUT:   out_q <= wr_data;
               SEL_POLARITY: pol_q <= wr_data;
               SEL_CONFIG:   cfg_q <= wr_data;
               default: ;
            endcase
         end
         if (rd_cap) snap_q <= pin_s;
      end
   end

   always_comb begin
      case (sel)
         SEL_INPUT:    rd_data = pin_s ^ pol_q;
         SEL_OUTPUT:   rd_data = out_q;
         SEL_POLARITY: rd_data = pol_q;
         default:      rd_data = cfg_q;
      endcase
   end

   generate
      if (IRQ_INPUTS_ONLY) begin : g_watch_inputs
         assign watch = cfg_q;
      end else begin : g_watch_all
         assign watch = '1;
      end
   endgenerate

   assign pin_o  = out_q;
   assign pin_oe = ~cfg_q;
   assign int_n  = ~|((pin_s ^ snap_q) & watch);
endmodule

// File: rtl/gpio_expander_core.sv
module gpio_expander_core
   import gpx_pkg::*;
#(
   parameter int         NPINS           = 4,
   parameter logic [6:0] SLAVE_ADDR      = 7'h49,
   parameter int         SYNC_STAGES     = 2,
   parameter bit         IRQ_INPUTS_ONLY = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe,
   input  logic [NPINS-1:0] pin_i,
   output logic [NPINS-1:0] pin_o,
   output logic [NPINS-1:0] pin_oe,
   output logic             int_n
);
   generate
      if (NPINS < 2 || NPINS > GPX_BYTE_W) begin : g_bad_npins
         $error("NPINS must lie in 2..8");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [1:0]       bus_s;
   logic             scl_s, sda_s, wr_en, rd_cap;
   logic [NPINS-1:0] pin_s, wr_data, rd_data;
   gpx_sel_e         ptr;

   gpx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(bus_s)
   );
   assign scl_s = bus_s[1];
   assign sda_s = bus_s[0];

   gpx_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pin_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_i), .q(pin_s)
   );

   gpx_slave #(.NPINS(NPINS), .SLAVE_ADDR(SLAVE_ADDR)) u_slave (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .sda_oe(sda_oe),
      .wr_en(wr_en), .ptr(ptr), .wr_data(wr_data), .rd_data(rd_data), .rd_cap(rd_cap)
   );

   gpx_regfile #(.NPINS(NPINS), .IRQ_INPUTS_ONLY(IRQ_INPUTS_ONLY)) u_regs (
      .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .wr_en(wr_en), .sel(ptr),
      .wr_data(wr_data), .rd_cap(rd_cap), .rd_data(rd_data),
      .pin_o(pin_o), .pin_oe(pin_oe), .int_n(int_n)
   );
endmodule

// File: rtl/gpx_checker.sv
module gpx_checker #(
   parameter int NPINS = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NPINS-1:0] pin_o,
   input logic [NPINS-1:0] pin_oe,
   input logic             int_n,
   input logic             sda_oe,
   input logic             scl_s,
   input logic             wr_en,
   input logic             rd_cap,
   input logic [NPINS-1:0] pin_s
);
   AST_RESET_ALL_INPUTS: assert property (@(posedge clk) !rst_n |=> (pin_oe == '0 && int_n)); // R1

   AST_PADS_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(pin_o) && $stable(pin_oe))); // R5

   AST_INT_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_n) |-> (!$stable(pin_s) || !$stable(pin_oe))); // R7

   AST_READ_RELEASES_INT: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cap |=> (int_n || !$stable(pin_s))); // R8

   AST_SDA_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_s); // R9
endmodule

bind gpio_expander_core gpx_checker #(.NPINS(NPINS)) u_gpx_checker (
   .clk(clk), .rst_n(rst_n), .pin_o(pin_o), .pin_oe(pin_oe), .int_n(int_n),
   .sda_oe(sda_oe), .scl_s(scl_s), .wr_en(wr_en), .rd_cap(rd_cap), .pin_s(pin_s)
);

// File: tb/gpio_expander_core_tb_top.sv
module gpio_expander_core_tb_top;
   localparam int         CLK_PERIOD = 10;
   localparam int         QP         = 6;
   localparam logic [6:0] DEV        = 7'h49;

   typedef struct {
      string      req;
      logic [7:0] val;
   } exp_item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1, sda_m = 1'b1;
   logic [3:0] pin_i = 4'h0;
   logic       sda_oe, int_n;
   logic [3:0] pin_o, pin_oe;
   logic       sda_line;
   int         n_chk = 0, n_fail = 0;
   exp_item_t  exp_q[$];
   logic [7:0] mon_byte;
   event       mon_ev;

   always #(CLK_PERIOD/2) clk = ~clk;
   assign sda_line = sda_m & ~sda_oe;

   gpio_expander_core dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
      .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe), .int_n(int_n)
   );

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wait_cyc(QP);
      scl_m = 1'b1; wait_cyc(QP);
      sda_m = 1'b0; wait_cyc(QP);
      scl_m = 1'b0; wait_cyc(QP);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wait_cyc(QP);
      scl_m = 1'b1; wait_cyc(QP);
      sda_m = 1'b1; wait_cyc(QP);
   endtask

   task automatic send_bit(logic b);
      sda_m = b;    wait_cyc(QP);
      scl_m = 1'b1; wait_cyc(QP);
      scl_m = 1'b0; wait_cyc(QP);
   endtask

   task automatic recv_bit(output logic b);
      sda_m = 1'b1; wait_cyc(QP);
      scl_m = 1'b1; wait_cyc(QP);
      b = sda_line;
      scl_m = 1'b0; wait_cyc(QP);
   endtask

   task automatic write_byte(logic [7:0] d, output logic ack);
      logic a;
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      recv_bit(a);
      ack = ~a;
   endtask

   task automatic read_byte(logic master_ack, output logic [7:0] d);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         d[i] = b;
      end
      send_bit(~master_ack);
   endtask

   task automatic reg_write(logic [1:0] sel, logic [7:0] d);
      logic ack;
      bus_start();
      write_byte({DEV, 1'b0}, ack); check("R9 addr ack", {7'd0, ack}, 8'd1);
      write_byte({6'd0, sel}, ack);  check("R9 cmd ack", {7'd0, ack}, 8'd1);
      write_byte(d, ack);            check("R9 data ack", {7'd0, ack}, 8'd1);
      bus_stop();
   endtask

   // driver: pushes expected bytes, monitor compares what the slave shifts out
   task automatic reg_read(logic [1:0] sel, int nbytes, logic [7:0] exp, string req);
      logic       ack;
      logic [7:0] d;
      bus_start();
      write_byte({DEV, 1'b0}, ack);
      write_byte({6'd0, sel}, ack);
      bus_start();
      write_byte({DEV, 1'b1}, ack);
      for (int k = 0; k < nbytes; k++) begin
         exp_q.push_back('{req: req, val: exp});
         read_byte(k != nbytes - 1, d);
         mon_byte = d;
         ->mon_ev;
      end
      bus_stop();
   endtask

   initial begin : monitor
      exp_item_t it;
      forever begin
         @(mon_ev);
         it = exp_q.pop_front();
         check(it.req, mon_byte, it.val);
      end
   end

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : stimulus
      logic ack;
      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(5);
      // R1 reset state
      check("R1 pin_oe", {4'd0, pin_oe}, 8'h00);
      check("R1 int_n", {7'd0, int_n}, 8'h01);
      check("R1 pin_o", {4'd0, pin_o}, 8'h0F);
      reg_read(2'd1, 1, 8'h0F, "R1 output default");
      reg_read(2'd2, 1, 8'h00, "R1 polarity default");
      reg_read(2'd3, 1, 8'h0F, "R1 config default");
      reg_read(2'd0, 1, 8'h00, "R6 input idle");

      // R2 foreign address is not acknowledged and writes nothing
      bus_start();
      write_byte({7'h22, 1'b0}, ack);
      check("R2 foreign addr nack", {7'd0, ack}, 8'd0);
      write_byte(8'h03, ack);
      write_byte(8'h00, ack);
      bus_stop();
      check("R2 no change pin_oe", {4'd0, pin_oe}, 8'h00);

      // R4 direction, R5 output drive
      reg_write(2'd3, 8'h03);
      wait_cyc(4);
      check("R4 pin_oe", {4'd0, pin_oe}, 8'h0C);
      reg_write(2'd1, 8'h0A);
      wait_cyc(4);
      check("R5 pin_o", {4'd0, pin_o}, 8'h0A);
      reg_read(2'd1, 1, 8'h0A, "R3 output readback");

      // R6 inversion, R7 interrupt, R8 release on read
      reg_write(2'd2, 8'h05);
      pin_i = 4'b0011;
      wait_cyc(6);
      check("R7 int on input change", {7'd0, int_n}, 8'h00);
      reg_read(2'd0, 1, 8'h06, "R6 inverted input");
      wait_cyc(4);
      check("R8 int released by read", {7'd0, int_n}, 8'h01);

      // R7 output-direction pin ignored
      pin_i = 4'b1011;
      wait_cyc(6);
      check("R7 output pin ignored", {7'd0, int_n}, 8'h01);

      // R8 return to snapshot releases
      pin_i = 4'b1001;
      wait_cyc(6);
      check("R7 int asserted bit1", {7'd0, int_n}, 8'h00);
      pin_i = 4'b1011;
      wait_cyc(6);
      check("R8 int released on return", {7'd0, int_n}, 8'h01);

      // R10 write to input register discarded
      reg_write(2'd0, 8'hFF);
      reg_read(2'd0, 1, 8'h0E, "R10 input unchanged");
      reg_read(2'd1, 1, 8'h0A, "R10 output unchanged");

      // R3 multi-byte write stays on one register
      bus_start();
      write_byte({DEV, 1'b0}, ack);
      write_byte(8'hF1, ack);
      write_byte(8'h05, ack);
      write_byte(8'h0C, ack);
      bus_stop();
      wait_cyc(4);
      check("R3 last byte to output", {4'd0, pin_o}, 8'h0C);
      reg_read(2'd2, 1, 8'h05, "R3 polarity untouched");

      // R9 multi-byte read with master ACK
      reg_read(2'd3, 2, 8'h03, "R9 repeated read");

      // R11 reset mid-transfer
      bus_start();
      write_byte({DEV, 1'b0}, ack);
      write_byte(8'h03, ack);
      send_bit(1'b1);
      send_bit(1'b1);
      rst_n = 1'b0;
      wait_cyc(3);
      rst_n = 1'b1;
      sda_m = 1'b1;
      scl_m = 1'b1;
      wait_cyc(QP);
      check("R11 pin_oe after reset", {4'd0, pin_oe}, 8'h00);
      check("R11 pin_o after reset", {4'd0, pin_o}, 8'h0F);
      reg_read(2'd2, 1, 8'h00, "R11 polarity after reset");

      wait_cyc(10);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule